// File: doc/BRIEF.md
# SPI NOR Flash Command Front-End

This block sits behind a SPI byte shifter and interprets the byte stream of a serial NOR flash command set. Each transfer strobe delivers one received byte and the block answers with one response byte, registered and valid from the clock after the strobe. An active-low chip select frames commands. Raising it returns the decoder to its idle state but keeps the write-enable latch.

The first byte of a frame is an opcode. Address-carrying opcodes first collect a fixed count of further bytes. That count depends on the opcode and, for the two interleaved-I/O read opcodes, on the manufacturer byte of the part identity. The first three collected bytes form a big-endian address. The block then does one of three things:
- it streams read data from a storage engine,
- it streams program requests to the storage engine,
- it issues an erase request.

Status and identity opcodes return short byte sequences instead. Dual and quad lane variants are all handled as plain byte transfers.

The part identity, the extended identity and the array size (a power of two) are parameters. Storage is external. Reads use a combinational request/address/data path, and program and erase requests are single-cycle pulses.

Top module: `spi_nor_cmd_fe`

## Requirements
- R1: After reset, tx_byte is 0x00, the latch is clear, and prog_req, erase_req and err_pulse are low.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 answers on the next strobe with one status byte: bit 1 is the latch and all other bits are zero.
- R3: Opcode 0x9F answers the three identity bytes, most significant first. When the extended identity is nonzero, its two bytes follow, high byte first. After the last byte, the next strobe is decoded as an opcode.
- R4: Opcode 0x03 collects 3 bytes, and opcodes 0x0B, 0x3B and 0x6B collect 4. Every collected byte gets the response 0x00. Afterwards, each strobe returns the storage byte at the current address, and the address then increments. The address is the first three collected bytes, big-endian.
- R5: The loaded address is taken modulo ARRAY_BYTES. After ARRAY_BYTES-1 the read address wraps to 0.
- R6: Opcode 0xBB collects 4 bytes when the manufacturer byte (PART_ID[23:16]) is 0xEF or 0x01, and 5 bytes otherwise. Opcode 0xEB collects 6 bytes for those manufacturers and 8 otherwise.
- R7: Opcodes 0x02, 0xA2 and 0x32 collect 3 address bytes. Each later strobe pulses prog_req with prog_addr set to the current address and prog_data set to the received byte, then increments the address. This happens whatever the latch state, and the response is 0x00.
- R8: Opcodes 0x20, 0x52 and 0xD8 collect 3 bytes. If the latch is set, the last byte pulses erase_req with erase_kind 0, 1 or 2 respectively, and erase_addr is the address modulo ARRAY_BYTES. With the latch clear, nothing is requested. The decoder then returns to idle.
- R9: Opcode 0xC7 pulses erase_req with erase_kind 3 and address 0, but only when the latch is set.
- R10: With the latch set, opcode 0x01 collects one byte and then clears the latch. With the latch clear, it is ignored and the next byte is decoded as an opcode.
- R11: While cs_n is high, strobes are ignored and no request is issued. A new frame starts decoding at an opcode. The latch is retained across frames.
- R12: An opcode outside the set pulses err_pulse for one cycle and has no other effect. Opcode 0x00 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rx_valid | input | 1 | Transfer strobe, one byte per cycle high |
| rx_byte | input | 8 | Byte received from the shifter |
| tx_byte | output | 8 | Response byte for the latest strobe |
| rd_req | output | 1 | Read of rd_addr consumed this cycle |
| rd_addr | output | 24 | Current storage address |
| rd_data | input | 8 | Storage byte at rd_addr (combinational) |
| prog_req | output | 1 | Program pulse |
| prog_addr | output | 24 | Program address |
| prog_data | output | 8 | Program byte |
| erase_req | output | 1 | Erase pulse |
| erase_kind | output | 2 | 0: 4 KiB, 1: 32 KiB, 2: sector, 3: whole array |
| erase_addr | output | 24 | Erase start address |
| err_pulse | output | 1 | Unknown opcode seen |

## Verification
The bench builds two instances on shared inputs, each with a 4 KiB array. The first has manufacturer byte 0xEF and no extended identity. The second has manufacturer byte 0x20 and extended identity 0x4D01. Comparing them on the same stream exposes both collection lengths of the interleaved-I/O reads, and both the three-byte and the five-byte identity answer. The small array also brings address wrap and modulo loading within a few strobes.

// File: rtl/spi_nor_cmd_fe.sv
module spi_nor_cmd_fe #(
  parameter logic [23:0] PART_ID     = 24'hEF4015,
  parameter logic [15:0] PART_EXT_ID = 16'h0000,
  parameter int          ARRAY_BYTES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic [7:0]  tx_byte,
  output logic        rd_req,
  output logic [23:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        prog_req,
  output logic [23:0] prog_addr,
  output logic [7:0]  prog_data,
  output logic        erase_req,
  output logic [1:0]  erase_kind,
  output logic [23:0] erase_addr,
  output logic        err_pulse
);
  localparam logic [23:0] AMASK    = 24'(ARRAY_BYTES - 1);
  localparam logic [7:0]  MFR      = PART_ID[23:16];
  localparam bit          SHORT_IO = (MFR == 8'hEF) || (MFR == 8'h01);
  localparam logic [2:0]  ID_LAST  = (PART_EXT_ID != 16'h0) ? 3'd4 : 3'd2;

  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRDI = 8'h04, OP_RDSR = 8'h05,
                         OP_WREN = 8'h06, OP_RDID = 8'h9F, OP_CHIP = 8'hC7;

  typedef enum logic [2:0] {S_IDLE, S_COLLECT, S_READ, S_PROG, S_REPLY} st_t;

  st_t         st;
  logic [7:0]  cmd;
  logic [3:0]  cnt, need;
  logic [2:0]  pos;
  logic [23:0] hdr, cur_addr;
  logic        wel;

  function automatic logic [3:0] collect_len(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32, 8'h20, 8'h52, 8'hD8: return 4'd3;
      8'h0B, 8'h3B, 8'h6B: return 4'd4;
      8'hBB: return SHORT_IO ? 4'd4 : 4'd5;
      8'hEB: return SHORT_IO ? 4'd6 : 4'd8;
      8'h01: return 4'd1;
      default: return 4'd0;
    endcase
  endfunction

  wire        stb      = rx_valid && !cs_n;
  wire [23:0] hdr_next = (cnt < 4'd3) ? {hdr[15:0], rx_byte} : hdr;
  wire [23:0] addr_inc = (cur_addr == AMASK) ? 24'd0 : cur_addr + 24'd1;
  wire [2:0]  rep_last = (cmd == OP_RDSR) ? 3'd0 : ID_LAST;
  wire [3:0]  cnt_inc  = cnt + 4'd1;

  logic [7:0] reply;
  always_comb begin
    if (cmd == OP_RDSR) reply = {6'b0, wel, 1'b0};
    else begin
      case (pos)
        3'd0:    reply = PART_ID[23:16];
        3'd1:    reply = PART_ID[15:8];
        3'd2:    reply = PART_ID[7:0];
        3'd3:    reply = PART_EXT_ID[15:8];
        default: reply = PART_EXT_ID[7:0];
      endcase
    end
  end

  assign rd_req  = stb && (st == S_READ);
  assign rd_addr = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cmd <= 8'h0; cnt <= 4'd0; need <= 4'd0; pos <= 3'd0;
      hdr <= 24'd0; cur_addr <= 24'd0; wel <= 1'b0; tx_byte <= 8'h0;
      prog_req <= 1'b0; prog_addr <= 24'd0; prog_data <= 8'h0;
      erase_req <= 1'b0; erase_kind <= 2'd0; erase_addr <= 24'd0;
      err_pulse <= 1'b0;
    end else begin
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      err_pulse <= 1'b0;
      if (cs_n) begin
        st <= S_IDLE; cnt <= 4'd0; pos <= 3'd0;
      end else if (rx_valid) begin
        tx_byte <= 8'h00;
        case (st)
          S_IDLE: begin
            cmd <= rx_byte; cnt <= 4'd0; pos <= 3'd0; hdr <= 24'd0;
            if (collect_len(rx_byte) != 4'd0 && (rx_byte != OP_WRSR || wel)) begin
              need <= collect_len(rx_byte);
              st   <= S_COLLECT;
            end else begin
              case (rx_byte)
                OP_WREN: wel <= 1'b1;
                OP_WRDI: wel <= 1'b0;
                OP_RDSR, OP_RDID: st <= S_REPLY;
                OP_CHIP: if (wel) begin
                  erase_req <= 1'b1; erase_kind <= 2'd3; erase_addr <= 24'd0;
                end
                OP_WRSR, 8'h00: ;
                default: err_pulse <= 1'b1;
              endcase
            end
          end
          S_COLLECT: begin
            hdr <= hdr_next;
            cnt <= cnt_inc;
            if (cnt_inc == need) begin
              st       <= S_IDLE;
              cur_addr <= hdr_next & AMASK;
              case (cmd)
                8'h02, 8'hA2, 8'h32: st <= S_PROG;
                8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB: st <= S_READ;
                8'h20, 8'h52, 8'hD8: if (wel) begin
                  erase_req  <= 1'b1;
                  erase_addr <= hdr_next & AMASK;
                  erase_kind <= (cmd == 8'h20) ? 2'd0 : (cmd == 8'h52) ? 2'd1 : 2'd2;
                end
                OP_WRSR: wel <= 1'b0;
                default: ;
              endcase
            end
          end
          S_READ: begin
            tx_byte  <= rd_data;
            cur_addr <= addr_inc;
          end
          S_PROG: begin
            prog_req  <= 1'b1;
            prog_addr <= cur_addr;
            prog_data <= rx_byte;
            cur_addr  <= addr_inc;
          end
          S_REPLY: begin
            tx_byte <= reply;
            pos     <= pos + 3'd1;
            if (pos == rep_last) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_nor_cmd_fe_chk.sv
module spi_nor_cmd_fe_chk #(
  parameter int ARRAY_BYTES = 4096
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rx_valid,
  input logic        wel,
  input logic        rd_req,
  input logic [23:0] rd_addr,
  input logic        prog_req,
  input logic        erase_req,
  input logic        err_pulse
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !prog_req && !erase_req && !err_pulse); // R11
  AST_WEL_HELD_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(wel)); // R11
  AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wel)); // R8
  AST_ERR_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(rx_valid && !cs_n)); // R12
  AST_PROG_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> $past(rx_valid && !cs_n)); // R7
  AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr < 24'(ARRAY_BYTES)); // R5
endmodule

bind spi_nor_cmd_fe spi_nor_cmd_fe_chk #(.ARRAY_BYTES(ARRAY_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .wel(wel),
  .rd_req(rd_req), .rd_addr(rd_addr), .prog_req(prog_req),
  .erase_req(erase_req), .err_pulse(err_pulse)
);

// File: tb/spi_nor_cmd_fe_tb.sv
module spi_nor_cmd_fe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SIZE = 4096;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]  tx_a, tx_b, rdd_a, rdd_b, pdat_a, pdat_b;
  logic        rdr_a, rdr_b, pr_a, pr_b, er_a, er_b, err_a, err_b;
  logic [23:0] rda_a, rda_b, pa_a, pa_b, ea_a, ea_b;
  logic [1:0]  ek_a, ek_b;

  function automatic logic [7:0] mem_of(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  assign rdd_a = mem_of(rda_a);
  assign rdd_b = mem_of(rda_b);

  spi_nor_cmd_fe #(.PART_ID(24'hEF4015), .PART_EXT_ID(16'h0000), .ARRAY_BYTES(SIZE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_a), .rd_req(rdr_a), .rd_addr(rda_a), .rd_data(rdd_a),
    .prog_req(pr_a), .prog_addr(pa_a), .prog_data(pdat_a),
    .erase_req(er_a), .erase_kind(ek_a), .erase_addr(ea_a), .err_pulse(err_a));

  spi_nor_cmd_fe #(.PART_ID(24'h20BA18), .PART_EXT_ID(16'h4D01), .ARRAY_BYTES(SIZE)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx_b), .rd_req(rdr_b), .rd_addr(rda_b), .rd_data(rdd_b),
    .prog_req(pr_b), .prog_addr(pa_b), .prog_data(pdat_b),
    .erase_req(er_b), .erase_kind(ek_b), .erase_addr(ea_b), .err_pulse(err_b));

  int checks = 0, errs = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic desel();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic one_cmd(input logic [7:0] op);
    sel(); xfer(op); desel();
  endtask

  function automatic int need_a(input logic [7:0] op);
    case (op)
      8'h03: return 3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: return 4;
      default: return 6;
    endcase
  endfunction

  task automatic read_burst(input logic [7:0] op, input logic [23:0] addr, input int len);
    logic [11:0] a;
    a = addr[11:0];
    sel(); xfer(op);
    for (int i = 0; i < need_a(op); i++) begin
      xfer((i == 0) ? addr[23:16] : (i == 1) ? addr[15:8] : (i == 2) ? addr[7:0] : 8'($urandom));
      chk("R4 collect response", tx_a, 8'h00);
    end
    for (int k = 0; k < len; k++) begin
      xfer(8'($urandom));
      chk("R4/R5 read data", tx_a, mem_of(24'(a)));
      a = a + 12'd1;
    end
    desel();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx reset", tx_a, 8'h00);
    chk("R1 req reset", {pr_a, er_a, err_a}, 3'b000);
    sel(); xfer(8'h05); xfer(8'h00); desel();
    chk("R1 latch clear", tx_a, 8'h00);

    one_cmd(8'h06);
    sel(); xfer(8'h05); xfer(8'h00);
    chk("R2 status after set", tx_a, 8'h02);
    xfer(8'h05);
    chk("R2 status ends, next is opcode", tx_a, 8'h00);
    xfer(8'h00);
    chk("R2 status again", tx_a, 8'h02);
    desel();
    one_cmd(8'h04);
    sel(); xfer(8'h05); xfer(8'h00); desel();
    chk("R2 status after clear", tx_a, 8'h00);

    sel(); xfer(8'h9F);
    xfer(8'h00); chk("R3 id0 a", tx_a, 8'hEF); chk("R3 id0 b", tx_b, 8'h20);
    xfer(8'h00); chk("R3 id1 a", tx_a, 8'h40); chk("R3 id1 b", tx_b, 8'hBA);
    xfer(8'h00); chk("R3 id2 a", tx_a, 8'h15); chk("R3 id2 b", tx_b, 8'h18);
    xfer(8'h00); chk("R3 a back to idle", tx_a, 8'h00); chk("R3 ext hi b", tx_b, 8'h4D);
    xfer(8'h00); chk("R3 ext lo b", tx_b, 8'h01);
    xfer(8'h05); chk("R3 b back to idle", tx_b, 8'h00);
    desel();

    read_burst(8'h03, 24'h000123, 5);
    read_burst(8'h0B, 24'h000FFE, 4);
    read_burst(8'h03, 24'hABCFFD, 5);

    sel(); xfer(8'hBB); xfer(8'h00); xfer(8'h01); xfer(8'h00); xfer(8'h77);
    xfer(8'h00);
    chk("R6 BB short a", tx_a, mem_of(24'h100)); chk("R6 BB long b", tx_b, 8'h00);
    xfer(8'h00);
    chk("R6 BB a next", tx_a, mem_of(24'h101)); chk("R6 BB b data", tx_b, mem_of(24'h100));
    desel();
    sel(); xfer(8'hEB); xfer(8'h00); xfer(8'h02); xfer(8'h00);
    xfer(8'h00); xfer(8'h00); xfer(8'h00);
    xfer(8'h00); chk("R6 EB a data", tx_a, mem_of(24'h200)); chk("R6 EB b 7th", tx_b, 8'h00);
    xfer(8'h00); chk("R6 EB b 8th", tx_b, 8'h00);
    xfer(8'h00); chk("R6 EB a third", tx_a, mem_of(24'h202)); chk("R6 EB b data", tx_b, mem_of(24'h200));
    desel();

    for (int n = 0; n < 30; n++) begin
      logic [7:0] ops [6];
      ops = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB};
      read_burst(ops[$urandom_range(5)], 24'($urandom), $urandom_range(1, 16));
    end

    for (int n = 0; n < 20; n++) begin
      logic [7:0] pops [3];
      logic [23:0] ad;
      logic [11:0] a;
      pops = '{8'h02, 8'hA2, 8'h32};
      ad = 24'($urandom);
      if (n == 0) ad = 24'h000FFF;
      a = ad[11:0];
      sel(); xfer(pops[$urandom_range(2)]);
      xfer(ad[23:16]); xfer(ad[15:8]); xfer(ad[7:0]);
      chk("R7 no prog during address", pr_a, 1'b0);
      for (int k = 0; k < 6; k++) begin
        logic [7:0] d;
        d = 8'($urandom);
        xfer(d);
        chk("R7 prog pulse", {pr_a, tx_a}, {1'b1, 8'h00});
        chk("R7 prog addr", pa_a, 24'(a));
        chk("R7 prog data", pdat_a, d);
        a = a + 12'd1;
      end
      desel();
    end

    sel(); xfer(8'h20); xfer(8'h00); xfer(8'h03); xfer(8'h00); desel();
    chk("R8 erase blocked", er_a, 1'b0);
    one_cmd(8'h06);
    sel(); xfer(8'h20); xfer(8'h00); xfer(8'h03); xfer(8'h00);
    chk("R8 erase 4k", {er_a, ek_a}, {1'b1, 2'd0}); chk("R8 erase addr", ea_a, 24'h000300);
    xfer(8'h05); xfer(8'h00); chk("R8 back to idle", tx_a, 8'h02);
    desel();
    sel(); xfer(8'h52); xfer(8'h12); xfer(8'h08); xfer(8'h00); desel();
    sel(); xfer(8'h52); xfer(8'h12); xfer(8'h08); xfer(8'h00);
    chk("R8 erase 32k", {er_a, ek_a}, {1'b1, 2'd1}); chk("R8 erase addr mod", ea_a, 24'h000800);
    desel();
    sel(); xfer(8'hD8); xfer(8'h00); xfer(8'h00); xfer(8'h40);
    chk("R8 erase sector", {er_a, ek_a, ea_a}, {1'b1, 2'd2, 24'h000040});
    desel();
    sel(); xfer(8'hC7);
    chk("R9 chip erase", {er_a, ek_a, ea_a}, {1'b1, 2'd3, 24'h0});
    desel();

    sel(); xfer(8'h01); xfer(8'h55); xfer(8'h05); xfer(8'h00);
    chk("R10 status write clears latch", tx_a, 8'h00);
    desel();
    sel(); xfer(8'hC7); chk("R9 chip erase blocked", er_a, 1'b0); desel();
    sel(); xfer(8'h01); xfer(8'h9F); xfer(8'h00);
    chk("R10 ignored without latch", tx_a, 8'hEF);
    desel();

    sel(); xfer(8'h03); xfer(8'h00); desel();
    xfer(8'h06);
    chk("R11 strobe while deselected", {pr_a, er_a, err_a}, 3'b000);
    sel(); xfer(8'h05); xfer(8'h00);
    chk("R11 fresh frame and latch untouched", tx_a, 8'h00);
    desel();
    one_cmd(8'h06);
    sel(); xfer(8'h02); xfer(8'h00); desel();
    sel(); xfer(8'h05); xfer(8'h00);
    chk("R11 latch kept across frames", tx_a, 8'h02);
    desel();

    sel(); xfer(8'h77);
    chk("R12 unknown flagged", err_a, 1'b1);
    xfer(8'h00);
    chk("R12 nop not flagged", err_a, 1'b0);
    xfer(8'h05); xfer(8'h00);
    chk("R12 no effect", tx_a, 8'h02);
    desel();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errs++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule